// File: doc/BRIEF.md
# Coherency Unit Control Register Block

This block is the memory-mapped register front end of a small multiprocessor coherency unit. A bus master reaches it through a simple slave port that carries a byte address inside a 256-byte window, a write strobe, an access size in bytes and 32-bit write data. The block holds three registers. The first is a single enable bit. The second is a read-only configuration word built from the number of cores, which is a parameter. The third is a 32-bit power status word, with one byte per core, that software can reach as a byte, a halfword or a whole word at any of its four byte offsets.

Every other offset in the window behaves as a hole. This covers the invalidate command, the filter address pair and the two access-control words. A hole returns zero on a read and ignores writes. A write whose size is not 1, 2 or 4 bytes is dropped entirely, whatever its address. Read data is registered: it appears on the read bus on the clock edge that accepts the read, and it holds until the next read.

Top module: `cu_regs_top`

## Requirements
- R1: A write of a valid size to offset 0x00 stores bit 0 of the write data as the enable bit. A read of 0x00 returns that bit in bit 0 and zero in bits 31:1.
- R2: A read of offset 0x04 returns the configuration word. Bits 1:0 hold NUM_CORES-1, bits 4 through 4+NUM_CORES-1 are ones, and every other bit is zero. NUM_CORES ranges from 1 to 4. Writes to 0x04 change nothing.
- R3: A read of offset 0x08+k, for k from 0 to 3, returns the power status word shifted right by 8*k bits, with zeros filling in from the top.
- R4: A write to offset 0x08+k with size 1, 2 or 4 replaces only the status bits under a mask of 0xFF, 0xFFFF or 0xFFFFFFFF shifted left by 8*k. Data that the shift moves above bit 31 is dropped.
- R5: req_size carries the access size as a byte count. A write whose size is anything other than 1, 2 or 4 leaves both the enable bit and the status word unchanged, at any offset.
- R6: Offset 0x0C, offsets 0x40, 0x44, 0x50 and 0x54, and every other offset except 0x00, 0x04 and 0x08 to 0x0B read as zero. Writes to any of these offsets change no state.
- R7: While reset is asserted, and after it is released, the enable bit, the status word and the read data output are all zero.
- R8: Read data is registered. The value for a read accepted at a clock edge appears on rsp_rdata after that same edge. The output holds its value through idle and write cycles until the next read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in the register window |
| req_size | input | 3 | Access size as a byte count (1, 2, 4 are valid) |
| req_wdata | input | 32 | Write data, right-aligned to the lowest lane |
| rsp_rdata | output | 32 | Registered read data |

## Verification
A write takes effect at the clock edge that accepts it, so the first read launched after that edge sees the new value. The value a read returns is on rsp_rdata after the same edge that accepts the read. The bench therefore drives each request on a falling edge and lets one rising edge pass. It samples rsp_rdata at the next falling edge, never at a rising one. Checks that something is ignored read back the enable bit and every status byte through the normal read path right after the ignored write. The hold check samples the output across several idle cycles and across a write.

// File: rtl/cu_regs_pkg.sv
package cu_regs_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned WIN_AW  = 8;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned LANE_W  = 8;

  localparam logic [WIN_AW-1:0] OFS_ENABLE = 8'h00;
  localparam logic [WIN_AW-1:0] OFS_CONFIG = 8'h04;
  localparam logic [WIN_AW-1:0] OFS_POWER  = 8'h08;

  function automatic logic [WORD_W-1:0] config_word(input int unsigned cores);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int unsigned i = 0; i < 4; i++) begin
      if (i < cores) w[4+i] = 1'b1;
    end
    w[1:0] = 2'(cores - 1);
    return w;
  endfunction

  function automatic logic size_is_legal(input logic [SIZE_W-1:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction

  function automatic logic [WORD_W-1:0] size_mask(input logic [SIZE_W-1:0] s);
    case (s)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cu_rst_sync.sv
module cu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cu_wr_lanes.sv
module cu_wr_lanes
  import cu_regs_pkg::*;
(
  input  logic              wr_req,
  input  logic [WIN_AW-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [WORD_W-1:0] wdata,
  output logic              enable_we,
  output logic              power_we,
  output logic [WORD_W-1:0] power_mask,
  output logic [WORD_W-1:0] power_data
);
  logic              legal;
  logic              hit_power;
  logic [4:0]        shamt;
  logic [WORD_W-1:0] base_mask;

  always_comb begin
    legal      = size_is_legal(size);
    hit_power  = (addr[WIN_AW-1:2] == OFS_POWER[WIN_AW-1:2]);
    shamt      = {addr[1:0], 3'b000};
    base_mask  = size_mask(size);
    enable_we  = wr_req && legal && (addr == OFS_ENABLE);
    power_we   = wr_req && legal && hit_power;
    power_mask = base_mask << shamt;
    power_data = (wdata & base_mask) << shamt;
  end
endmodule

// File: rtl/cu_power_word.sv
module cu_power_word #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LANE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] word_q
);
  localparam int unsigned LANES = WIDTH / LANE;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE-1:0] lane_q;
    logic [LANE-1:0] lane_d;
    logic            lane_en;

    always_comb begin
      lane_en = we && (|mask[g*LANE +: LANE]);
      lane_d  = (lane_q & ~mask[g*LANE +: LANE]) |
                (data[g*LANE +: LANE] & mask[g*LANE +: LANE]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= lane_d;
    end

    assign word_q[g*LANE +: LANE] = lane_q;
  end
endmodule

// File: rtl/cu_rd_mux.sv
module cu_rd_mux
  import cu_regs_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1
) (
  input  logic [WIN_AW-1:0] addr,
  input  logic              enable_q,
  input  logic [WORD_W-1:0] power_q,
  output logic [WORD_W-1:0] rd_value
);
  localparam logic [WORD_W-1:0] CFG_VALUE = config_word(NUM_CORES);

  always_comb begin
    rd_value = '0;
    if (addr == OFS_ENABLE)
      rd_value = {{(WORD_W-1){1'b0}}, enable_q};
    else if (addr == OFS_CONFIG)
      rd_value = CFG_VALUE;
    else if (addr[WIN_AW-1:2] == OFS_POWER[WIN_AW-1:2])
      rd_value = power_q >> {addr[1:0], 3'b000};
  end
endmodule

// File: rtl/cu_regs_top.sv
module cu_regs_top
  import cu_regs_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WIN_AW-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] rsp_rdata
);
  logic              rst_sync_n;
  logic              wr_req;
  logic              rd_req;
  logic              enable_we;
  logic              power_we;
  logic [WORD_W-1:0] power_mask;
  logic [WORD_W-1:0] power_data;
  logic [WORD_W-1:0] power_q;
  logic              enable_q;
  logic              enable_d;
  logic [WORD_W-1:0] rd_value;
  logic [WORD_W-1:0] rdata_q;

  cu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    wr_req = req_valid && req_write;
    rd_req = req_valid && !req_write;
  end

  cu_wr_lanes u_wr_lanes (
    .wr_req    (wr_req),
    .addr      (req_addr),
    .size      (req_size),
    .wdata     (req_wdata),
    .enable_we (enable_we),
    .power_we  (power_we),
    .power_mask(power_mask),
    .power_data(power_data)
  );

  cu_power_word #(.WIDTH(WORD_W), .LANE(LANE_W)) u_power_word (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (power_we),
    .mask  (power_mask),
    .data  (power_data),
    .word_q(power_q)
  );

  always_comb enable_d = req_wdata[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    enable_q <= 1'b0;
    else if (enable_we) enable_q <= enable_d;
  end

  cu_rd_mux #(.NUM_CORES(NUM_CORES)) u_rd_mux (
    .addr    (req_addr),
    .enable_q(enable_q),
    .power_q (power_q),
    .rd_value(rd_value)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_value;
  end

  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/cu_regs_chk.sv
module cu_regs_chk
  import cu_regs_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [WIN_AW-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic              wbit0,
  input logic              enable_q,
  input logic [WORD_W-1:0] power_q,
  input logic [WORD_W-1:0] rsp_rdata
);
  logic rd, wr, ok_size, is_power, is_mapped, is_writable;
  logic [WORD_W-1:0] cfg_expect;

  always_comb begin
    rd          = req_valid && !req_write;
    wr          = req_valid && req_write;
    ok_size     = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
    is_power    = (req_addr >= 8'h08) && (req_addr <= 8'h0B);
    is_mapped   = (req_addr == 8'h00) || (req_addr == 8'h04) || is_power;
    is_writable = (req_addr == 8'h00) || is_power;
    cfg_expect  = ((32'd1 << NUM_CORES) - 32'd1) << 4 | 32'(NUM_CORES - 1);
  end

  p_enable_narrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == 8'h00) |=> (rsp_rdata[WORD_W-1:1] == '0));

  p_enable_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ok_size && req_addr == 8'h00) |=> (enable_q == $past(wbit0)));

  p_config_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == 8'h04) |=> (rsp_rdata == cfg_expect));

  p_bad_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ok_size) |=> ($stable(enable_q) && $stable(power_q)));

  p_hole_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !is_writable) |=> ($stable(enable_q) && $stable(power_q)));

  p_hole_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !is_mapped) |=> (rsp_rdata == '0));

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rsp_rdata));
endmodule

bind cu_regs_top cu_regs_chk #(.NUM_CORES(NUM_CORES)) u_cu_regs_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_size (req_size),
  .wbit0    (req_wdata[0]),
  .enable_q (enable_q),
  .power_q  (power_q),
  .rsp_rdata(rsp_rdata)
);

// File: tb/test_cu_regs_top.sv
module test_cu_regs_top;
  localparam int unsigned CORES = 4;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  logic        m_en;
  logic [31:0] m_pwr;

  cu_regs_top #(.NUM_CORES(CORES)) i_cu_regs_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_en};
    if (a == 8'h04) return ((32'd1 << CORES) - 32'd1) << 4 | 32'(CORES - 1);
    if (a >= 8'h08 && a <= 8'h0B) return m_pwr >> (8 * (a - 8'h08));
    return 32'h0;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = 3'd4;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic expect_read(input string req, input logic [7:0] a);
    logic [31:0] d;
    bus_read(a, d);
    check(req, $sformatf("read @%h", a), d, model_read(a));
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_en = 1'b0; m_pwr = '0;
  endtask

  task automatic t_reset();
    apply_reset();
    check("R7", "rdata after reset", rsp_rdata, 32'h0);
    expect_read("R7", 8'h00);
    expect_read("R7", 8'h08);
  endtask

  task automatic t_config();
    expect_read("R2", 8'h04);
    check("R2", "config literal", model_read(8'h04), 32'h0000_00F3);
    bus_write(8'h04, 3'd4, 32'hFFFF_FFFF);
    expect_read("R2", 8'h04);
    expect_read("R2", 8'h00);
    expect_read("R2", 8'h08);
  endtask

  task automatic t_enable();
    bus_write(8'h00, 3'd4, 32'hFFFF_FFFE); m_en = 1'b0;
    expect_read("R1", 8'h00);
    bus_write(8'h00, 3'd1, 32'h0000_0003); m_en = 1'b1;
    expect_read("R1", 8'h00);
    bus_write(8'h00, 3'd2, 32'h0000_0000); m_en = 1'b0;
    expect_read("R1", 8'h00);
    bus_write(8'h00, 3'd4, 32'h8000_0001); m_en = 1'b1;
    expect_read("R1", 8'h00);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    bus_write(8'h08, 3'd4, 32'h1122_3344); m_pwr = 32'h1122_3344;
    for (int k = 0; k < 4; k++) expect_read("R3", 8'(8 + k));
    bus_read(8'h09, d); check("R3", "shift by one lane", d, 32'h0011_2233);
    bus_write(8'h0A, 3'd1, 32'hFFFF_FFAB); m_pwr = 32'h11AB_3344;
    expect_read("R4", 8'h08);
    bus_write(8'h09, 3'd2, 32'hFFFF_BEEF); m_pwr = 32'h11BE_EF44;
    expect_read("R4", 8'h08);
    bus_write(8'h0B, 3'd4, 32'hCCDD_EEFF); m_pwr = 32'hFFBE_EF44;
    expect_read("R4", 8'h08);
    bus_write(8'h0B, 3'd2, 32'h0000_1234); m_pwr = 32'h34BE_EF44;
    expect_read("R4", 8'h08);
    bus_read(8'h0B, d); check("R3", "top lane", d, 32'h0000_0034);
  endtask

  task automatic t_bad_size();
    logic [2:0] bad [4] = '{3'd0, 3'd3, 3'd5, 3'd7};
    for (int i = 0; i < 4; i++) begin
      bus_write(8'h08, bad[i], 32'h0000_0000);
      bus_write(8'h0A, bad[i], 32'h0000_0055);
      bus_write(8'h00, bad[i], {31'b0, ~m_en});
    end
    for (int k = 0; k < 4; k++) expect_read("R5", 8'(8 + k));
    expect_read("R5", 8'h00);
  endtask

  task automatic t_holes();
    logic [7:0] holes [7] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01, 8'hFF};
    for (int i = 0; i < 7; i++) begin
      bus_write(holes[i], 3'd4, 32'hFFFF_FFFF);
      expect_read("R6", holes[i]);
      expect_read("R6", 8'h00);
      expect_read("R6", 8'h08);
    end
  endtask

  task automatic t_hold();
    logic [31:0] d;
    bus_read(8'h08, d);
    check("R8", "registered value", d, m_pwr);
    repeat (4) begin
      @(negedge clk);
      check("R8", "idle hold", rsp_rdata, m_pwr);
    end
    bus_write(8'h08, 3'd4, 32'hA5A5_5A5A);
    check("R8", "hold across write", rsp_rdata, m_pwr);
    m_pwr = 32'hA5A5_5A5A;
    expect_read("R8", 8'h08);
  endtask

  task automatic t_reset_again();
    bus_write(8'h00, 3'd1, 32'h1); m_en = 1'b1;
    apply_reset();
    check("R7", "rdata after second reset", rsp_rdata, 32'h0);
    expect_read("R7", 8'h00);
    expect_read("R7", 8'h08);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = 3'd4; req_wdata = '0;
    m_en = 1'b0; m_pwr = '0;
    t_reset();
    t_config();
    t_enable();
    t_lanes();
    t_bad_size();
    t_holes();
    t_hold();
    t_reset_again();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule